// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the address-phase engine of a bus master. A command carrying a start address, a burst type, a beat size and, for open-ended incrementing bursts, a beat count is taken in while the sequencer is idle. The block then presents one beat per accepted bus cycle on its address, transfer-type, burst-type and size outputs. It moves on only when the bus ready input is high.

Addresses step by the beat size. Wrapping bursts fold back inside their aligned block. An open-ended incrementing burst that reaches a 1KB region edge is restarted with a fresh first-beat marking. A stall request from the data source turns into pause (BUSY) cycles that keep the burst position. A one-cycle completion pulse follows acceptance of the last beat. When the block has no work, it drives the idle transfer type.

Top module: `burst_addr_gen`

## Requirements
- R1: On incrementing bursts (burst codes 001, 011, 101, 111) each beat address is the previous one plus 2^size bytes. Size code 0 is byte, 1 is halfword and 2 is word; code 3 is treated as word.
- R2: Wrapping bursts (burst code 010 = 4 beats, 100 = 8 beats, 110 = 16 beats) keep every address inside the block aligned to beats × 2^size bytes. An address that would pass the block end continues from the block start.
- R3: Transfer type is encoded 00 idle, 01 busy, 10 first beat (NONSEQ) and 11 following beat (SEQ). The first beat of each burst is 10, and every later beat is 11 unless R7 applies.
- R4: A burst issues exactly its number of beats: 1 for SINGLE (code 000), 4, 8 or 16 for the fixed types, and the command count for INCR (code 001). A count of 0 is taken as 1.
- R5: While the source stall input is high and a further SEQ beat remains, the block drives BUSY. It holds the next beat's address until the stall clears and then issues that address as SEQ. The stall has no effect when no beat remains or when the next beat starts a new burst, so SINGLE never shows BUSY.
- R6: While the bus ready input is low during a burst, address, transfer type, burst type and size stay unchanged.
- R7: In an INCR burst, a beat whose address lies on a 1KB boundary is issued as a first beat (10), which starts a new burst.
- R8: The done output is high for exactly one cycle. That cycle is the one after the last beat is accepted, and it shows the idle transfer type.
- R9: After reset, and whenever no burst is in progress, the transfer type is idle, done is low and cmd_ready is high. A command is taken on a clock edge where cmd_valid and cmd_ready are both high. Its first beat appears on the next cycle.
- R10: The burst-type and size outputs carry the accepted command's values, with size clamped as in R1, for every beat of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_addr | input | ADDR_W | Start address |
| cmd_burst | input | 3 | Burst type code |
| cmd_size | input | 2 | Beat size code |
| cmd_len | input | CNT_W | Beat count for INCR |
| src_stall | input | 1 | Source not ready, request a pause |
| hready | input | 1 | Bus accepts the current address phase |
| haddr | output | ADDR_W | Beat address |
| htrans | output | 2 | Transfer type |
| hburst | output | 3 | Burst type |
| hsize | output | 3 | Beat size |
| done | output | 1 | Last beat accepted |

## Verification
A corrupted beat counter shows at the ports in the cycle after the affected acceptance. It appears as an idle transfer where a SEQ beat was due, or a SEQ beat after the burst should have ended. A wrong address register shows on the very next beat as a step that differs from 2^size, or as a wrapping address outside its block. A transfer-type state stuck in BUSY or SEQ shows within one cycle as a missing resume or a missing first-beat marking at a 1KB edge. The bench predicts every cycle, so it flags each of these in the cycle where it first appears.

// File: rtl/bag_pkg.sv
package bag_pkg;
   typedef enum logic [1:0] {
      TR_IDLE = 2'b00,
      TR_BUSY = 2'b01,
      TR_NSEQ = 2'b10,
      TR_SEQ  = 2'b11
   } trans_e;

   localparam logic [2:0] BT_SINGLE = 3'b000;
   localparam logic [2:0] BT_INCR   = 3'b001;

   // wrapping codes are the even, non-zero ones
   function automatic logic is_wrap(input logic [2:0] b);
      return (b != BT_SINGLE) && !b[0];
   endfunction

   // log2 of beats for the fixed-length codes: 01x->2, 10x->3, 11x->4
   function automatic logic [2:0] fixed_lg(input logic [2:0] b);
      return {1'b0, b[2:1]} + 3'd1;
   endfunction
endpackage

// File: rtl/bag_beat_count.sv
module bag_beat_count
   import bag_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic [2:0]       burst,
   input  logic [CNT_W-1:0] len,
   output logic [CNT_W-1:0] beats
);
   always_comb begin
      if (burst == BT_SINGLE)
         beats = CNT_W'(1);
      else if (burst == BT_INCR)
         beats = (len == '0) ? CNT_W'(1) : len;
      else
         beats = CNT_W'(1) << fixed_lg(burst);
   end
endmodule

// File: rtl/bag_addr_step.sv
module bag_addr_step
   import bag_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int BOUND_LG = 10,
   parameter bit SPLIT    = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic [2:0]        burst,
   output logic [ADDR_W-1:0] nxt,
   output logic              new_region
);
   logic [ADDR_W-1:0] inc;
   logic [ADDR_W-1:0] lin;
   logic [ADDR_W-1:0] mask;
   logic [2:0]        blk_lg;

   always_comb begin
      inc    = ADDR_W'(1) << size;
      lin    = addr + inc;
      blk_lg = fixed_lg(burst) + {1'b0, size};
      mask   = (ADDR_W'(1) << blk_lg) - ADDR_W'(1);
      if (is_wrap(burst))
         nxt = (addr & ~mask) | (lin & mask);
      else
         nxt = lin;
   end

   generate
      if (SPLIT) begin : g_split
         assign new_region = (burst == BT_INCR) && (lin[BOUND_LG-1:0] == '0);
      end else begin : g_nosplit
         assign new_region = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import bag_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int CNT_W    = 8,
   parameter int BOUND_LG = 10,
   parameter bit SPLIT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [2:0]        cmd_burst,
   input  logic [1:0]        cmd_size,
   input  logic [CNT_W-1:0]  cmd_len,
   input  logic              src_stall,
   input  logic              hready,
   output logic [ADDR_W-1:0] haddr,
   output logic [1:0]        htrans,
   output logic [2:0]        hburst,
   output logic [2:0]        hsize,
   output logic              done
);
   localparam int MIN_CNT_W = 5;
   localparam int MIN_BLG   = 6;

   generate
      if (CNT_W < MIN_CNT_W) begin : g_bad_cnt
         $error("CNT_W must hold a count of 16");
      end
      if (BOUND_LG < MIN_BLG || BOUND_LG >= ADDR_W) begin : g_bad_bound
         $error("BOUND_LG must cover the largest wrap block and fit the address");
      end
   endgenerate

   trans_e            tr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [1:0]        size_q;
   logic [2:0]        burst_q;
   logic [CNT_W-1:0]  left_q;
   logic              done_q;

   logic [1:0]        size_in;
   logic [CNT_W-1:0]  beats_in;
   logic [ADDR_W-1:0] addr_nxt;
   logic              region_nxt;

   assign size_in = (cmd_size == 2'd3) ? 2'd2 : cmd_size;

   bag_beat_count #(.CNT_W(CNT_W)) u_cnt (
      .burst (cmd_burst),
      .len   (cmd_len),
      .beats (beats_in)
   );

   bag_addr_step #(.ADDR_W(ADDR_W), .BOUND_LG(BOUND_LG), .SPLIT(SPLIT)) u_step (
      .addr       (addr_q),
      .size       (size_q),
      .burst      (burst_q),
      .nxt        (addr_nxt),
      .new_region (region_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tr_q    <= TR_IDLE;
         addr_q  <= '0;
         size_q  <= '0;
         burst_q <= BT_SINGLE;
         left_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (tr_q == TR_IDLE) begin
            if (cmd_valid) begin
               addr_q  <= cmd_addr;
               size_q  <= size_in;
               burst_q <= cmd_burst;
               left_q  <= beats_in;
               tr_q    <= TR_NSEQ;
            end
         end else if (hready) begin
            if (tr_q == TR_BUSY) begin
               if (!src_stall) tr_q <= TR_SEQ;
            end else if (left_q == CNT_W'(1)) begin
               tr_q   <= TR_IDLE;
               left_q <= '0;
               done_q <= 1'b1;
            end else begin
               addr_q <= addr_nxt;
               left_q <= left_q - CNT_W'(1);
               if (region_nxt)     tr_q <= TR_NSEQ;
               else if (src_stall) tr_q <= TR_BUSY;
               else                tr_q <= TR_SEQ;
            end
         end
      end
   end

   assign cmd_ready = (tr_q == TR_IDLE);
   assign haddr     = addr_q;
   assign htrans    = tr_q;
   assign hburst    = burst_q;
   assign hsize     = {1'b0, size_q};
   assign done      = done_q;
endmodule

// File: rtl/bag_chk.sv
module bag_chk
   import bag_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int BOUND_LG = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hready,
   input logic [ADDR_W-1:0] haddr,
   input logic [1:0]        htrans,
   input logic [2:0]        hburst,
   input logic [2:0]        hsize,
   input logic              done
);
   logic [2:0] blk_lg;
   assign blk_lg = fixed_lg(hburst) + hsize;

   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (hready && htrans[1] && hburst[0]) |=>
      (htrans == TR_IDLE || haddr == $past(haddr) + (ADDR_W'(1) << $past(hsize))));

   a_r2_wrap_block: assert property (@(posedge clk) disable iff (!rst_n)
      (hready && htrans[1] && is_wrap(hburst)) |=>
      (htrans == TR_IDLE || (haddr >> blk_lg) == ($past(haddr) >> blk_lg)));

   a_r3_first_nseq: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(htrans) == TR_IDLE && htrans != TR_IDLE) |-> htrans == TR_NSEQ);

   a_r5_busy_resume: assert property (@(posedge clk) disable iff (!rst_n)
      (htrans == TR_BUSY) |=> ((htrans == TR_BUSY || htrans == TR_SEQ) && $stable(haddr)));

   a_r5_single_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (hburst == BT_SINGLE) |-> htrans != TR_BUSY);

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!hready && htrans != TR_IDLE) |=>
      ($stable(haddr) && $stable(htrans) && $stable(hburst) && $stable(hsize)));

   a_r7_region: assert property (@(posedge clk) disable iff (!rst_n)
      (htrans == TR_SEQ && hburst == BT_INCR) |-> haddr[BOUND_LG-1:0] != '0);

   a_r8_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (htrans == TR_IDLE && $past(hready)));

   a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind burst_addr_gen bag_chk #(.ADDR_W(ADDR_W), .BOUND_LG(BOUND_LG)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .hready (hready),
   .haddr  (haddr),
   .htrans (htrans),
   .hburst (hburst),
   .hsize  (hsize),
   .done   (done)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
   localparam int ADDR_W = 32;
   localparam int CNT_W  = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic              cmd_ready;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [2:0]        cmd_burst = '0;
   logic [1:0]        cmd_size = '0;
   logic [CNT_W-1:0]  cmd_len = '0;
   logic              src_stall = 1'b0;
   logic              hready = 1'b1;
   logic [ADDR_W-1:0] haddr;
   logic [1:0]        htrans;
   logic [2:0]        hburst;
   logic [2:0]        hsize;
   logic              done;

   burst_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_addr(cmd_addr), .cmd_burst(cmd_burst), .cmd_size(cmd_size), .cmd_len(cmd_len),
      .src_stall(src_stall), .hready(hready), .haddr(haddr), .htrans(htrans),
      .hburst(hburst), .hsize(hsize), .done(done)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // ---- reference model: expected beat list computed from the requirements ----
   logic [31:0] qa[$];
   bit          qn[$];
   int          exp_beats;
   logic [1:0]  e_tr = 2'b00;
   logic [31:0] e_addr = '0;
   logic        e_done = 1'b0;
   logic [2:0]  e_burst = '0;
   logic [2:0]  e_size = '0;

   function automatic void build(input logic [2:0] b, input logic [1:0] s,
                                 input logic [31:0] a, input logic [7:0] l);
      int n;
      int by;
      logic [31:0] blk, base, ad;
      by = 1 << ((s == 2'd3) ? 2 : s);
      case (b)
         3'd0:       n = 1;
         3'd1:       n = (l == 0) ? 1 : int'(l);
         3'd2, 3'd3: n = 4;
         3'd4, 3'd5: n = 8;
         default:    n = 16;
      endcase
      qa.delete();
      qn.delete();
      if (b == 3'd2 || b == 3'd4 || b == 3'd6) begin
         blk  = n * by;
         base = a - (a % blk);
         for (int i = 0; i < n; i++) begin
            qa.push_back(base + ((a - base + i * by) % blk));
            qn.push_back(i == 0);
         end
      end else begin
         for (int i = 0; i < n; i++) begin
            ad = a + i * by;
            qa.push_back(ad);
            qn.push_back(i == 0 || (b == 3'd1 && (ad % 1024) == 0));
         end
      end
      exp_beats = n;
      e_burst   = b;
      e_size    = (s == 2'd3) ? 3'd2 : {1'b0, s};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         e_tr   = 2'b00;
         e_done = 1'b0;
      end else begin
         e_done = 1'b0;
         if (e_tr == 2'b00) begin
            if (cmd_valid) begin
               build(cmd_burst, cmd_size, cmd_addr, cmd_len);
               e_addr = qa.pop_front();
               void'(qn.pop_front());
               e_tr = 2'b10;
            end
         end else if (hready) begin
            if (e_tr == 2'b01) begin
               if (!src_stall) begin
                  e_addr = qa.pop_front();
                  void'(qn.pop_front());
                  e_tr = 2'b11;
               end
            end else if (qa.size() == 0) begin
               e_tr   = 2'b00;
               e_done = 1'b1;
            end else if (qn[0]) begin
               e_addr = qa.pop_front();
               void'(qn.pop_front());
               e_tr = 2'b10;
            end else if (src_stall) begin
               e_addr = qa[0];
               e_tr   = 2'b01;
            end else begin
               e_addr = qa.pop_front();
               void'(qn.pop_front());
               e_tr = 2'b11;
            end
         end
      end
   end

   // ---- per-cycle comparison and port-level counters ----
   int seen_beats = 0;
   int busy_seen  = 0;
   int nseq_seen  = 0;
   bit prev_rdy   = 1'b1;
   bit cmp_on     = 1'b0;

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         string ttag;
         string atag;
         ttag = (e_tr == 2'b01 || htrans == 2'b01) ? "R5" : (!prev_rdy ? "R6" : "R3");
         chk(htrans == e_tr, ttag, 32'(htrans), 32'(e_tr));
         chk(done == e_done, "R8", 32'(done), 32'(e_done));
         chk(cmd_ready == (e_tr == 2'b00), "R9", 32'(cmd_ready), 32'(e_tr == 2'b00));
         if (e_tr != 2'b00) begin
            if (!prev_rdy) atag = "R6";
            else if (e_burst == 3'd2 || e_burst == 3'd4 || e_burst == 3'd6) atag = "R2";
            else if (e_burst == 3'd1) atag = "R7";
            else atag = "R1";
            chk(haddr == e_addr, atag, haddr, e_addr);
            chk(hburst == e_burst, "R10", 32'(hburst), 32'(e_burst));
            chk(hsize == e_size, "R10", 32'(hsize), 32'(e_size));
         end
         if (hready && htrans[1]) seen_beats++;
         if (hready && htrans == 2'b10) nseq_seen++;
         if (htrans == 2'b01) busy_seen++;
         prev_rdy = (htrans != 2'b00) ? hready : 1'b1;
      end
   end

   // ---- stimulus of ready and stall, changed shortly after each rising edge ----
   int rdy_mode = 0;    // 0 always high, 1 random
   int stall_mode = 0;  // 0 never, 1 random, 2 always
   always @(posedge clk) begin
      #2;
      hready    <= (rdy_mode == 0) ? 1'b1 : (($urandom % 10) < 6);
      src_stall <= (stall_mode == 0) ? 1'b0 :
                   (stall_mode == 2) ? 1'b1 : (($urandom % 2) == 0);
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic run(input logic [2:0] b, input logic [1:0] s,
                      input logic [31:0] a, input logic [7:0] l);
      do begin @(posedge clk); #3; end while (!cmd_ready);
      seen_beats = 0;
      busy_seen  = 0;
      nseq_seen  = 0;
      cmd_burst  = b;
      cmd_size   = s;
      cmd_addr   = a;
      cmd_len    = l;
      cmd_valid  = 1'b1;
      @(posedge clk); #3;
      cmd_valid  = 1'b0;
      while (!done) begin @(posedge clk); #3; end
      // R4: exact beat count per burst
      chk(seen_beats == exp_beats, "R4", 32'(seen_beats), 32'(exp_beats));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #3;
      // R9: reset state
      chk(htrans == 2'b00, "R9", 32'(htrans), 32'd0);
      chk(done == 1'b0, "R9", 32'(done), 32'd0);
      chk(cmd_ready == 1'b1, "R9", 32'(cmd_ready), 32'd1);
      rst_n = 1'b1;
      @(posedge clk); #3;
      cmd_on_start();

      // R1: word INCR4 from 0 gives 0,4,8,C
      run(3'b011, 2'd2, 32'h0, 8'd0);
      run(3'b101, 2'd0, 32'h13, 8'd0);
      run(3'b111, 2'd1, 32'h100, 8'd0);
      run(3'b011, 2'd3, 32'h200, 8'd0);   // R1 size 3 acts as word
      // R2: wrapping
      run(3'b010, 2'd2, 32'h38, 8'd0);
      run(3'b100, 2'd1, 32'h1A, 8'd0);
      run(3'b110, 2'd0, 32'h7, 8'd0);
      run(3'b110, 2'd2, 32'h84, 8'd0);
      // R4: SINGLE and zero-length INCR
      run(3'b000, 2'd0, 32'h55, 8'd0);
      run(3'b001, 2'd1, 32'h40, 8'd0);
      // R7: INCR across a 1KB edge restarts with a first beat
      run(3'b001, 2'd2, 32'h3F0, 8'd10);
      chk(nseq_seen == 2, "R7", 32'(nseq_seen), 32'd2);

      // R5: stall pauses
      stall_mode = 1;
      run(3'b101, 2'd2, 32'h1000, 8'd0);
      run(3'b100, 2'd2, 32'h2010, 8'd0);
      run(3'b001, 2'd0, 32'h7FA, 8'd12);
      stall_mode = 2;
      run(3'b000, 2'd2, 32'h300, 8'd0);
      chk(busy_seen == 0, "R5", 32'(busy_seen), 32'd0);
      run(3'b001, 2'd2, 32'h3FC, 8'd2);
      chk(busy_seen == 0, "R5", 32'(busy_seen), 32'd0);
      stall_mode = 0;

      // R6: ready low periods
      rdy_mode = 1;
      run(3'b111, 2'd2, 32'h500, 8'd0);
      run(3'b110, 2'd1, 32'h61E, 8'd0);
      // mixed ready and stall
      stall_mode = 1;
      for (int k = 0; k < 12; k++) begin
         run(3'(k % 8), 2'(k % 3), 32'h3C0 + 32'(k * 36), 8'(k + 3));
      end
      begin
         int bsum = 0;
         for (int k = 0; k < 6; k++) begin
            run(3'b101, 2'd1, 32'h900 + 32'(k * 16), 8'd0);
            bsum += busy_seen;
         end
         chk(bsum > 0, "R5", 32'(bsum), 32'd1);
      end
      stall_mode = 0;
      rdy_mode   = 0;
      repeat (3) @(posedge clk);
      #3;
      chk(htrans == 2'b00 && cmd_ready, "R9", 32'(htrans), 32'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic cmd_on_start();
      cmp_on = 1'b1;
   endtask
endmodule